// File: doc/BRIEF.md
# Integer Execute Unit

This block is the integer execute stage of a 32-bit RISC core. Each cycle it may take one instruction word together with the values of the two source registers that the instruction names. It produces the arithmetic, logic, compare, shift, sign-extension or multiply result, the index of the register that receives it, and a write enable. Every output is registered, so results appear one clock after the instruction is presented.

The 6-bit opcode sits in instruction bits 31:26. Register-register forms read the registers named at bits 25:21 and 20:16 and write the register named at bits 15:11. Bits 10:0 of these forms must be zero. Register-immediate forms read the register at bits 25:21 and write the register at bits 20:16. Their 16-bit immediate comes from bits 15:0.

The caller supplies the source values on `src_a`, which is the register at 25:21, and `src_b`, which is the register at 20:16. The immediate forms ignore `src_b`. Compares do not set flags. They write 0 or 1 into the destination register. A write aimed at register 0 is suppressed.

Top module: `int_exec_unit`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs clear to zero: `out_valid`, `out_wen`, `out_result` and `out_dest`.
- R2: `out_valid` equals the `in_valid` of the previous cycle. When `in_valid` was low, `out_wen` is 0 and `out_result` and `out_dest` keep their previous values.
- R3: The register-register opcodes compute as follows: 45 gives A+B, 50 gives A-B, 40 gives A&B, 46 gives A|B, 38 gives A^B, 41 gives ~(A^B) and 33 gives ~(A|B).
- R4: Multiply returns the low 32 bits of the product. Opcode 34 computes A*B. Opcode 2 computes A times the sign-extended immediate.
- R5: Register shifts use the low 5 bits of B as the amount: 47 is left, 37 is arithmetic right and 32 is logical right. Immediate shifts use instruction bits 4:0 as the amount: 15 is left, 5 is arithmetic right and 0 is logical right.
- R6: Opcode 13 adds A to the sign-extended immediate. Opcodes 25, 26, 27 and 31 compare A against the sign-extended immediate for equal, signed greater, signed greater-or-equal and not-equal.
- R7: The following opcodes use the zero-extended immediate: 8 (and), 14 (or), 6 (xor), 1 (nor), 9 (xnor), 28 (unsigned greater-or-equal compare) and 29 (unsigned greater compare).
- R8: Opcode 24 ANDs A with the immediate placed in bits 31:16, with zeros below. Opcode 30 ORs A with the same value.
- R9: The register compares are 57 (equal), 63 (not equal), 58 (signed greater), 59 (signed greater-or-equal), 61 (unsigned greater) and 60 (unsigned greater-or-equal). They, and the compare immediates, produce exactly 1 when the relation holds and 0 otherwise.
- R10: Opcode 44 sign-extends bits 7:0 of A to 32 bits. Opcode 55 sign-extends bits 15:0 of A.
- R11: `out_dest` carries instruction bits 15:11 for register-register forms and bits 20:16 for immediate forms.
- R12: When the destination index is 0, `out_wen` is 0, even though the instruction is otherwise accepted.
- R13: `out_wen` is 0 for any opcode not listed in R3 to R10. It is also 0 for a register-register form, including 44 and 55, whose bits 10:0 are not all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_insn | input | 32 | Instruction word |
| src_a | input | 32 | Value of register at bits 25:21 |
| src_b | input | 32 | Value of register at bits 20:16 |
| out_valid | output | 1 | Registered strobe, one cycle after in_valid |
| out_wen | output | 1 | Destination write enable |
| out_result | output | 32 | Computed result |
| out_dest | output | 5 | Destination register index |

## Verification
Three of this block's functions can fall in the same cycle: the destination-zero suppression, the reserved-bit check, and a fully valid computation. Bits 15:0 act as the immediate for one opcode class and as the destination plus reserved field for the other. The same instruction word is therefore applied to all 64 opcodes, with bit patterns chosen so that one word can be a legal immediate form, an illegal register form, and a write to register 0. The bench judges each outcome separately: the result against an arithmetic model, the destination index, and the write enable.

// File: rtl/exec_pkg.sv
package exec_pkg;

  localparam int OPC_W = 6;

  typedef enum logic [4:0] {
    K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_XNOR, K_NOR, K_MUL,
    K_SLL, K_SRA, K_SRL, K_CEQ, K_CNE, K_CGT, K_CGE, K_CGTU,
    K_CGEU, K_SEXB, K_SEXH
  } alu_kind_e;

  typedef enum logic [1:0] {
    B_REG, B_SIGNED, B_UNSIGNED, B_UPPER
  } bsel_e;

  typedef struct packed {
    alu_kind_e kind;
    bsel_e     bsel;
    logic      three_reg;
    logic      legal;
  } exec_ctrl_t;

endpackage

// File: rtl/exec_decode.sv
module exec_decode
  import exec_pkg::*;
#(
  parameter int RSV_W = 11
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic [RSV_W-1:0] rsv_bits,
  output exec_ctrl_t       ctrl
);

  logic rsv_clear;
  assign rsv_clear = (rsv_bits == '0);

  always_comb begin
    ctrl.kind      = K_ADD;
    ctrl.bsel      = B_REG;
    ctrl.three_reg = 1'b1;
    ctrl.legal     = rsv_clear;
    case (opcode)
      6'd45: ctrl.kind = K_ADD;
      6'd50: ctrl.kind = K_SUB;
      6'd40: ctrl.kind = K_AND;
      6'd46: ctrl.kind = K_OR;
      6'd38: ctrl.kind = K_XOR;
      6'd41: ctrl.kind = K_XNOR;
      6'd33: ctrl.kind = K_NOR;
      6'd34: ctrl.kind = K_MUL;
      6'd47: ctrl.kind = K_SLL;
      6'd37: ctrl.kind = K_SRA;
      6'd32: ctrl.kind = K_SRL;
      6'd57: ctrl.kind = K_CEQ;
      6'd63: ctrl.kind = K_CNE;
      6'd58: ctrl.kind = K_CGT;
      6'd59: ctrl.kind = K_CGE;
      6'd61: ctrl.kind = K_CGTU;
      6'd60: ctrl.kind = K_CGEU;
      6'd44: ctrl.kind = K_SEXB;
      6'd55: ctrl.kind = K_SEXH;
      default: begin
        ctrl.three_reg = 1'b0;
        ctrl.legal     = 1'b1;
        case (opcode)
          6'd13: begin ctrl.kind = K_ADD;  ctrl.bsel = B_SIGNED;   end
          6'd2:  begin ctrl.kind = K_MUL;  ctrl.bsel = B_SIGNED;   end
          6'd25: begin ctrl.kind = K_CEQ;  ctrl.bsel = B_SIGNED;   end
          6'd26: begin ctrl.kind = K_CGT;  ctrl.bsel = B_SIGNED;   end
          6'd27: begin ctrl.kind = K_CGE;  ctrl.bsel = B_SIGNED;   end
          6'd31: begin ctrl.kind = K_CNE;  ctrl.bsel = B_SIGNED;   end
          6'd8:  begin ctrl.kind = K_AND;  ctrl.bsel = B_UNSIGNED; end
          6'd14: begin ctrl.kind = K_OR;   ctrl.bsel = B_UNSIGNED; end
          6'd6:  begin ctrl.kind = K_XOR;  ctrl.bsel = B_UNSIGNED; end
          6'd1:  begin ctrl.kind = K_NOR;  ctrl.bsel = B_UNSIGNED; end
          6'd9:  begin ctrl.kind = K_XNOR; ctrl.bsel = B_UNSIGNED; end
          6'd28: begin ctrl.kind = K_CGEU; ctrl.bsel = B_UNSIGNED; end
          6'd29: begin ctrl.kind = K_CGTU; ctrl.bsel = B_UNSIGNED; end
          6'd15: begin ctrl.kind = K_SLL;  ctrl.bsel = B_UNSIGNED; end
          6'd5:  begin ctrl.kind = K_SRA;  ctrl.bsel = B_UNSIGNED; end
          6'd0:  begin ctrl.kind = K_SRL;  ctrl.bsel = B_UNSIGNED; end
          6'd24: begin ctrl.kind = K_AND;  ctrl.bsel = B_UPPER;    end
          6'd30: begin ctrl.kind = K_OR;   ctrl.bsel = B_UPPER;    end
          default: ctrl.legal = 1'b0;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/exec_operand.sv
module exec_operand
  import exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  bsel_e             bsel,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] reg_b,
  output logic [DATA_W-1:0] opnd_b
);

  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_s, imm_z, imm_u;

  assign imm_s = {{PAD_W{imm[IMM_W-1]}}, imm};
  assign imm_z = {{PAD_W{1'b0}}, imm};

  generate
    if (PAD_W >= IMM_W) begin : g_upper_fits
      assign imm_u = {{(PAD_W-IMM_W){1'b0}}, imm, {IMM_W{1'b0}}};
    end else begin : g_upper_trunc
      assign imm_u = {imm[PAD_W-1:0], {IMM_W{1'b0}}};
    end
  endgenerate

  always_comb begin
    case (bsel)
      B_SIGNED:   opnd_b = imm_s;
      B_UNSIGNED: opnd_b = imm_z;
      B_UPPER:    opnd_b = imm_u;
      default:    opnd_b = reg_b;
    endcase
  end

endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_kind_e         kind,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);

  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0]   amt;
  logic [DATA_W-1:0] prod;
  logic              eq, gt_s, gt_u;

  assign amt  = b[SH_W-1:0];
  assign prod = a * b;
  assign eq   = (a == b);
  assign gt_s = ($signed(a) > $signed(b));
  assign gt_u = (a > b);

  always_comb begin
    y = '0;
    case (kind)
      K_ADD:  y = a + b;
      K_SUB:  y = a - b;
      K_AND:  y = a & b;
      K_OR:   y = a | b;
      K_XOR:  y = a ^ b;
      K_XNOR: y = ~(a ^ b);
      K_NOR:  y = ~(a | b);
      K_MUL:  y = prod;
      K_SLL:  y = a << amt;
      K_SRA:  y = $unsigned($signed(a) >>> amt);
      K_SRL:  y = a >> amt;
      K_CEQ:  y[0] = eq;
      K_CNE:  y[0] = ~eq;
      K_CGT:  y[0] = gt_s;
      K_CGE:  y[0] = gt_s | eq;
      K_CGTU: y[0] = gt_u;
      K_CGEU: y[0] = gt_u | eq;
      K_SEXB: y = {{(DATA_W-8){a[7]}}, a[7:0]};
      K_SEXH: y = {{(DATA_W-16){a[15]}}, a[15:0]};
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import exec_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       in_insn,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic              out_valid,
  output logic              out_wen,
  output logic [DATA_W-1:0] out_result,
  output logic [IDX_W-1:0]  out_dest
);

  localparam int OPC_LSB  = 32 - OPC_W;
  localparam int RB_LSB   = OPC_LSB - 2*IDX_W;
  localparam int RD_LSB   = RB_LSB - IDX_W;

  exec_ctrl_t        ctrl;
  logic [DATA_W-1:0] opnd_b, alu_y;
  logic [IDX_W-1:0]  dest;
  logic [OPC_W-1:0]  opcode;

  assign opcode = in_insn[31:OPC_LSB];

  exec_decode #(.RSV_W(RD_LSB)) u_dec (
    .opcode   (opcode),
    .rsv_bits (in_insn[RD_LSB-1:0]),
    .ctrl     (ctrl)
  );

  exec_operand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opnd (
    .bsel   (ctrl.bsel),
    .imm    (in_insn[IMM_W-1:0]),
    .reg_b  (src_b),
    .opnd_b (opnd_b)
  );

  exec_alu #(.DATA_W(DATA_W)) u_alu (
    .kind (ctrl.kind),
    .a    (src_a),
    .b    (opnd_b),
    .y    (alu_y)
  );

  assign dest = ctrl.three_reg ? in_insn[RD_LSB+IDX_W-1:RD_LSB]
                               : in_insn[RB_LSB+IDX_W-1:RB_LSB];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_wen    <= 1'b0;
      out_result <= '0;
      out_dest   <= '0;
    end else begin
      out_valid <= in_valid;
      out_wen   <= in_valid && ctrl.legal && (dest != '0);
      if (in_valid) begin
        out_result <= alu_y;
        out_dest   <= dest;
      end
    end
  end

  // R2: strobe follows the input one cycle later
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  a_r2_wen_needs_valid: assert property (@(posedge clk) disable iff (rst)
    out_wen |-> out_valid);

  a_r12_no_zero_write: assert property (@(posedge clk) disable iff (rst)
    out_wen |-> (out_dest != '0));

  a_r9_compare_boolean: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && (in_insn[31:26] inside {6'd57, 6'd58, 6'd59, 6'd60,
      6'd61, 6'd63, 6'd25, 6'd26, 6'd27, 6'd28, 6'd29, 6'd31}))
    |-> (out_result[DATA_W-1:1] == '0));

  a_r10_sextb_upper: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && in_insn[31:26] == 6'd44)
    |-> ((out_result[DATA_W-1:7] == '0) || (&out_result[DATA_W-1:7])));

  a_r13_unsupported_silent: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && in_insn[31:26] == 6'd35) |-> !out_wen);

endmodule

// File: tb/int_exec_unit_tb.sv
module int_exec_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_insn, src_a, src_b;
  logic        out_valid, out_wen;
  logic [31:0] out_result;
  logic [4:0]  out_dest;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  int_exec_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .out_wen(out_wen),
    .out_result(out_result), .out_dest(out_dest)
  );

  function automatic void chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s insn=%08h a=%08h b=%08h actual=%08h expected=%08h",
               tag, in_insn, src_a, src_b, act, exp);
    end
  endfunction

  function automatic logic [63:0] pat(int i);
    case (i)
      0: return {32'h0000_0000, 32'h0000_0000};
      1: return {32'h0000_0001, 32'h0000_0001};
      2: return {32'hFFFF_FFFF, 32'h0000_0001};
      3: return {32'h8000_0000, 32'h7FFF_FFFF};
      4: return {32'h7FFF_FFFF, 32'h8000_0000};
      5: return {32'h1234_5678, 32'h0000_001F};
      6: return {32'hDEAD_BEEF, 32'h0000_0021};
      7: return {32'h0000_0005, 32'hFFFF_FFFB};
      8: return {32'hFFFF_8000, 32'h0000_7FFF};
      default: return {32'h0000_0080, 32'h0000_8000};
    endcase
  endfunction

  // Expected outcome: {legal, three_reg, result}; tag names the requirement
  function automatic logic [33:0] model(logic [31:0] w, logic [31:0] a,
                                        logic [31:0] b, output string tag);
    logic [15:0] i;
    logic [31:0] si, zi, hi, r;
    logic        rr, lg;
    i  = w[15:0];
    si = {{16{i[15]}}, i};
    zi = {16'h0, i};
    hi = {i, 16'h0};
    rr = 1'b1; lg = (w[10:0] == 11'd0); r = 32'h0; tag = "R13";
    case (w[31:26])
      6'd45: begin r = a + b;       tag = "R3"; end
      6'd50: begin r = a - b;       tag = "R3"; end
      6'd40: begin r = a & b;       tag = "R3"; end
      6'd46: begin r = a | b;       tag = "R3"; end
      6'd38: begin r = a ^ b;       tag = "R3"; end
      6'd41: begin r = ~(a ^ b);    tag = "R3"; end
      6'd33: begin r = ~(a | b);    tag = "R3"; end
      6'd34: begin r = a * b;       tag = "R4"; end
      6'd47: begin r = a << b[4:0]; tag = "R5"; end
      6'd37: begin r = $unsigned($signed(a) >>> b[4:0]); tag = "R5"; end
      6'd32: begin r = a >> b[4:0]; tag = "R5"; end
      6'd57: begin r = {31'h0, a == b}; tag = "R9"; end
      6'd63: begin r = {31'h0, a != b}; tag = "R9"; end
      6'd58: begin r = {31'h0, $signed(a) > $signed(b)};  tag = "R9"; end
      6'd59: begin r = {31'h0, $signed(a) >= $signed(b)}; tag = "R9"; end
      6'd61: begin r = {31'h0, a > b};  tag = "R9"; end
      6'd60: begin r = {31'h0, a >= b}; tag = "R9"; end
      6'd44: begin r = {{24{a[7]}}, a[7:0]};   tag = "R10"; end
      6'd55: begin r = {{16{a[15]}}, a[15:0]}; tag = "R10"; end
      default: begin
        rr = 1'b0; lg = 1'b1;
        case (w[31:26])
          6'd13: begin r = a + si; tag = "R6"; end
          6'd2:  begin r = a * si; tag = "R4"; end
          6'd25: begin r = {31'h0, a == si}; tag = "R6"; end
          6'd26: begin r = {31'h0, $signed(a) > $signed(si)};  tag = "R6"; end
          6'd27: begin r = {31'h0, $signed(a) >= $signed(si)}; tag = "R6"; end
          6'd31: begin r = {31'h0, a != si}; tag = "R6"; end
          6'd8:  begin r = a & zi;    tag = "R7"; end
          6'd14: begin r = a | zi;    tag = "R7"; end
          6'd6:  begin r = a ^ zi;    tag = "R7"; end
          6'd1:  begin r = ~(a | zi); tag = "R7"; end
          6'd9:  begin r = ~(a ^ zi); tag = "R7"; end
          6'd28: begin r = {31'h0, a >= zi}; tag = "R7"; end
          6'd29: begin r = {31'h0, a > zi};  tag = "R7"; end
          6'd15: begin r = a << i[4:0]; tag = "R5"; end
          6'd5:  begin r = $unsigned($signed(a) >>> i[4:0]); tag = "R5"; end
          6'd0:  begin r = a >> i[4:0]; tag = "R5"; end
          6'd24: begin r = a & hi; tag = "R8"; end
          6'd30: begin r = a | hi; tag = "R8"; end
          default: begin lg = 1'b0; tag = "R13"; end
        endcase
      end
    endcase
    return {lg, rr, r};
  endfunction

  task automatic apply(logic [31:0] w, logic [31:0] a, logic [31:0] b);
    string       tag;
    logic [33:0] m;
    logic [4:0]  d;
    @(negedge clk);
    in_valid = 1'b1; in_insn = w; src_a = a; src_b = b;
    m = model(w, a, b, tag);
    d = m[32] ? w[15:11] : w[20:16];
    @(negedge clk);
    chk("R2 valid", {31'h0, out_valid}, 32'h1);
    chk("R11 dest", {27'h0, out_dest}, {27'h0, d});
    // R12 / R13: write enable only for a legal op with a nonzero destination
    chk((d == 5'd0) ? "R12 wen" : "R13 wen", {31'h0, out_wen},
        {31'h0, m[33] && (d != 5'd0)});
    if (m[33]) chk(tag, out_result, m[31:0]);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_insn = '0; src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid",  {31'h0, out_valid}, 32'h0);
    chk("R1 wen",    {31'h0, out_wen},   32'h0);
    chk("R1 result", out_result,         32'h0);
    chk("R1 dest",   {27'h0, out_dest},  32'h0);
    rst = 1'b0;
    for (int op = 0; op < 64; op++) begin
      for (int v = 0; v < 4; v++) begin
        for (int p = 0; p < 10; p++) begin
          logic [15:0] imm;
          logic [4:0]  ra, rb;
          logic [63:0] ab;
          case (v)
            0: imm = {5'd7, 11'h000};
            1: imm = {5'd19, 11'h000};
            2: imm = 16'h8F35;
            default: imm = 16'h0000;
          endcase
          ra = 5'(v * 5 + 1);
          rb = (v == 3) ? 5'd0 : 5'(v + 9);
          ab = pat(p);
          apply({6'(op), ra, rb, imm}, ab[63:32], ab[31:0]);
        end
      end
    end
    // R2: an idle cycle holds result and destination and drops the strobe
    apply({6'd45, 5'd1, 5'd2, 5'd4, 11'h0}, 32'd40, 32'd2);
    @(negedge clk);
    in_valid = 1'b0; in_insn = {6'd50, 5'd1, 5'd2, 5'd9, 11'h0};
    @(negedge clk);
    chk("R2 idle valid",  {31'h0, out_valid}, 32'h0);
    chk("R2 idle wen",    {31'h0, out_wen},   32'h0);
    chk("R2 idle result", out_result,         32'd42);
    chk("R2 idle dest",   {27'h0, out_dest},  32'd4);
    // R1: reset after activity clears everything
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reclear result", out_result, 32'h0);
    chk("R1 reclear dest",   {27'h0, out_dest}, 32'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule